// File: doc/BRIEF.md
# Receive Frame Scatter Unit

This block takes one received Ethernet frame as a stream of bytes and spreads it over a chain of receive descriptors kept in a small internal descriptor store. Each descriptor gives a buffer capacity and a buffer start address. The unit fills buffers in list order and emits 32-bit little-endian buffer writes with byte masks. When it finishes with a descriptor, it writes back the byte count it stored, a first/last marker, and a cleared valid flag.

A frame that fits in one buffer uses a single descriptor. A longer frame spills into the following descriptors, and the final buffer holds only the remainder. The step between descriptors is set by a length selector, so each descriptor can carry padding words. A wrap flag in a descriptor sends the pointer back to the list base. If the next descriptor is not owned by the unit while frame bytes remain, the unit discards the rest of the frame and flags an overflow in the descriptor it wrote last. Software fills the descriptor store and reads it back through a simple word port.

Top module: `rx_scatter`

## Requirements
- R1: After reset, `inReady` and `bufWrEn` are low, every descriptor word reads zero, and the descriptor pointer sits at `listBase`.
- R2: Descriptor layout, as word offsets from the descriptor start:
  - Word +0: bit 31 is valid (owned by the unit), bit 30 is wrap, bits 29:28 are the buffer position, bit 27 is overflow.
  - Word +1: bits 31:16 hold the capacity, bits 15:0 hold the stored count.
  - Word +2: the buffer byte address. Its two low bits are ignored, so buffers start on a 4-byte boundary.
- R3: A frame no longer than the capacity goes to one buffer. Its write-back has valid 0, position 11 and a count equal to the frame length. The next descriptor is left untouched.
- R4: When a buffer reaches its capacity and bytes remain, the next byte goes to offset 0 of the next descriptor's buffer. Positions are written as 10 for the first buffer, 00 for middle buffers and 01 for the last buffer. Full buffers report the capacity as their count, and the last buffer reports the remainder. For example, a capacity of 500 and a 1514-byte frame give counts of 500, 500, 500 and 14.
- R5: Frame byte n of a buffer goes to byte lane n mod 4 of the word at buffer address + (n rounded down to a multiple of 4).
  - A write is issued one cycle after the byte that completes a word or ends a buffer.
  - The mask covers only the bytes received, counted up from lane 0.
  - The words of all buffers together carry exactly the frame bytes.
- R6: The next descriptor starts 4, 8 or 16 words after the current one, for `descLenSel` values 0, 1 and 2. A value of 3 acts as 2.
- R7: After a descriptor with the wrap bit set, the next descriptor is taken at `listBase`. Write-back preserves the wrap bit.
- R8: If the next descriptor is not valid while frame bytes remain:
  - The unit still accepts the remaining bytes up to the frame's last byte, but writes none of them.
  - It sets bit 27 in word +0 of the descriptor it wrote back last.
  - The invalid descriptor stays current and receives the next frame once software sets its valid bit.
- R9: If the current descriptor is not valid when a frame starts, the whole frame is accepted and discarded. No buffer write and no write-back occur, and the pointer does not move.
- R10: `inReady` is low while the unit is idle or fetching a descriptor. The first byte of a frame is therefore taken no earlier than one cycle after `inValid` rises. `inReady` is low in the cycle after a last byte is taken.
- R11: Write-back changes only bits 31:27 of word +0 and bits 15:0 of word +1. The other bits of those words, and all of word +2, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| descLenSel | input | 2 | Descriptor step: 0 = 4 words, 1 = 8 words, 2 or 3 = 16 words |
| listBase | input | AW | Word index of the first descriptor in the list |
| inValid | input | 1 | Frame byte present |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the final byte of the frame |
| inReady | output | 1 | Unit takes the byte at this edge |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | 32 | Word-aligned buffer byte address |
| bufWrData | output | 32 | Little-endian write data |
| bufWrMask | output | 4 | Byte lane enables |
| dmWrEn | input | 1 | Descriptor store write from software |
| dmAddr | input | AW | Descriptor store word index |
| dmWrData | input | 32 | Descriptor store write data |
| dmRdData | output | 32 | Descriptor store read data at `dmAddr` |

## Verification
A wrong byte counter or buffer base shows up at the buffer write port within one cycle of the affected byte. It appears as a misplaced address, a broken lane mask, or bytes landing in the wrong buffer, and the bench spots it when it rebuilds each buffer from the captured writes. A wrong pointer, a wrong stride or a lost wrap leaves the wrong descriptor words changed, which shows in the descriptor store as soon as the buffer closes. A control state stuck in the wrong phase shows on `inReady`, either as a missed idle cycle at frame start or as a handshake that never completes.

// File: rtl/rxsc_pkg.sv
package rxsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NEXT,
    ST_RECV,
    ST_DROP
  } stateT;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic load;      // latch current descriptor, restart buffer
    logic firstBuf;  // qualifies load: descriptor opens the frame
    logic take;      // byte accepted this edge
    logic wb;        // close current buffer, write back, advance
    logic lastBuf;   // qualifies wb: buffer ends the frame
    logic ovf;       // flag overflow in previously written descriptor
  } strobeT;

endpackage

// File: rtl/rxsc_ctrl.sv
module rxsc_ctrl
  import rxsc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   descValid,
  input  logic   bufFull,
  output logic   inReady,
  output strobeT stb
);

  stateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    inReady   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          if (descValid) begin
            stb.load     = 1'b1;
            stb.firstBuf = 1'b1;
            nextState    = ST_RECV;
          end else begin
            nextState = ST_DROP;
          end
        end
      end
      ST_NEXT: begin
        if (descValid) begin
          stb.load  = 1'b1;
          nextState = ST_RECV;
        end else begin
          stb.ovf   = 1'b1;
          nextState = ST_DROP;
        end
      end
      ST_RECV: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.take = 1'b1;
          if (inLast) begin
            stb.wb      = 1'b1;
            stb.lastBuf = 1'b1;
            nextState   = ST_IDLE;
          end else if (bufFull) begin
            stb.wb    = 1'b1;
            nextState = ST_NEXT;
          end
        end
      end
      ST_DROP: begin
        inReady = 1'b1;
        if (inValid && inLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rxsc_datapath.sv
module rxsc_datapath
  import rxsc_pkg::*;
#(
  parameter  int DESC_WORDS = 64,
  localparam int AW         = $clog2(DESC_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    descLenSel,
  input  logic [AW-1:0] listBase,
  input  logic [7:0]    inData,
  input  strobeT        stb,
  output logic          descValid,
  output logic          bufFull,
  output logic          bufWrEn,
  output logic [31:0]   bufWrAddr,
  output logic [31:0]   bufWrData,
  output logic [3:0]    bufWrMask,
  input  logic          dmWrEn,
  input  logic [AW-1:0] dmAddr,
  input  logic [31:0]   dmWrData,
  output logic [31:0]   dmRdData
);

  logic [31:0]   descMem [DESC_WORDS];
  logic [AW-1:0] ptr, prevPtr, nextPtr, strideW;
  logic [AW-1:0] ptrW1, ptrW2;
  logic          wrapReg, firstReg;
  logic [26:0]   keepBits;
  logic [15:0]   capReg, cnt, cntInc;
  logic [31:0]   bufBase;
  logic [31:0]   accData;
  logic [3:0]    accMask;
  logic [1:0]    lane;
  logic          flush;

  assign ptrW1     = ptr + AW'(1);
  assign ptrW2     = ptr + AW'(2);
  assign descValid = descMem[ptr][31];
  assign dmRdData  = descMem[dmAddr];
  assign cntInc    = cnt + 16'd1;
  assign bufFull   = (cntInc == capReg);
  assign lane      = cnt[1:0];
  assign flush     = stb.take && ((lane == 2'd3) || stb.wb);

  always_comb begin
    unique case (descLenSel)
      2'd0:    strideW = AW'(4);
      2'd1:    strideW = AW'(8);
      default: strideW = AW'(16);
    endcase
  end

  assign nextPtr = wrapReg ? listBase : (ptr + strideW);

  // Descriptor store: software port, write-back, overflow flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_WORDS; i++) descMem[i] <= '0;
    end else begin
      if (dmWrEn) descMem[dmAddr] <= dmWrData;
      if (stb.wb) begin
        descMem[ptr]   <= {1'b0, wrapReg, firstReg, stb.lastBuf, 1'b0, keepBits};
        descMem[ptrW1] <= {capReg, cntInc};
      end
      if (stb.ovf) descMem[prevPtr][27] <= 1'b1;
    end
  end

  // Descriptor pointer and latched descriptor fields.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= listBase;
      prevPtr  <= listBase;
      wrapReg  <= 1'b0;
      firstReg <= 1'b0;
      keepBits <= '0;
      capReg   <= '0;
      bufBase  <= '0;
    end else begin
      if (stb.load) begin
        wrapReg  <= descMem[ptr][30];
        keepBits <= descMem[ptr][26:0];
        capReg   <= descMem[ptrW1][31:16];
        bufBase  <= {descMem[ptrW2][31:2], 2'b00};
        firstReg <= stb.firstBuf;
      end
      if (stb.wb) begin
        prevPtr <= ptr;
        ptr     <= nextPtr;
      end
    end
  end

  // Byte counter and word packer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      accData <= '0;
      accMask <= '0;
    end else if (stb.load) begin
      cnt     <= '0;
      accData <= '0;
      accMask <= '0;
    end else if (stb.take) begin
      cnt <= cntInc;
      if (flush) begin
        accData <= '0;
        accMask <= '0;
      end else begin
        accData[{lane, 3'b000} +: 8] <= inData;
        accMask[lane]                <= 1'b1;
      end
    end
  end

  // Registered buffer write port.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
      bufWrMask <= '0;
    end else begin
      bufWrEn <= flush;
      if (flush) begin
        bufWrAddr <= bufBase + {16'b0, cnt[15:2], 2'b00};
        bufWrData <= accData | ({24'b0, inData} << {lane, 3'b000});
        bufWrMask <= accMask | (4'b0001 << lane);
      end
    end
  end

endmodule

// File: rtl/rx_scatter.sv
module rx_scatter
  import rxsc_pkg::*;
#(
  parameter  int DESC_WORDS = 64,
  localparam int AW         = $clog2(DESC_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    descLenSel,
  input  logic [AW-1:0] listBase,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inLast,
  output logic          inReady,
  output logic          bufWrEn,
  output logic [31:0]   bufWrAddr,
  output logic [31:0]   bufWrData,
  output logic [3:0]    bufWrMask,
  input  logic          dmWrEn,
  input  logic [AW-1:0] dmAddr,
  input  logic [31:0]   dmWrData,
  output logic [31:0]   dmRdData
);

  strobeT stb;
  logic   descValid;
  logic   bufFull;

  rxsc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .descValid (descValid),
    .bufFull   (bufFull),
    .inReady   (inReady),
    .stb       (stb)
  );

  rxsc_datapath #(.DESC_WORDS(DESC_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .descLenSel (descLenSel),
    .listBase   (listBase),
    .inData     (inData),
    .stb        (stb),
    .descValid  (descValid),
    .bufFull    (bufFull),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .bufWrMask  (bufWrMask),
    .dmWrEn     (dmWrEn),
    .dmAddr     (dmAddr),
    .dmWrData   (dmWrData),
    .dmRdData   (dmRdData)
  );

endmodule

// File: rtl/rxsc_checker.sv
module rxsc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inLast,
  input logic        inReady,
  input logic        bufWrEn,
  input logic [31:0] bufWrAddr,
  input logic [3:0]  bufWrMask
);

  // R1: a reset cycle leaves the byte port closed and no write pending
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!inReady && !bufWrEn));

  // R5: every buffer write follows an accepted byte by one cycle
  p_write_after_take_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(inValid && inReady));

  // R5: lanes fill upward from lane 0
  p_mask_contig_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (bufWrMask == 4'b0001 || bufWrMask == 4'b0011 ||
                 bufWrMask == 4'b0111 || bufWrMask == 4'b1111));

  // R2, R5: buffer words are 4-byte aligned
  p_word_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (bufWrAddr[1:0] == 2'b00));

  // R10: the port closes after a frame's final byte
  p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  // R1: ready is never unknown out of reset
  p_ready_known_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(inReady));

endmodule

bind rx_scatter rxsc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inLast    (inLast),
  .inReady   (inReady),
  .bufWrEn   (bufWrEn),
  .bufWrAddr (bufWrAddr),
  .bufWrMask (bufWrMask)
);

// File: tb/rx_scatter_test.sv
module rx_scatter_test;

  localparam int AW  = 6;
  localparam int CAP = 16384;

  typedef struct packed {
    int capy;
    int len;
    int sel;
    int nBuf;
    int lastCnt;
  } vecT;

  localparam vecT VEC [0:6] = '{
    '{500, 1514, 0, 4, 14},
    '{ 64,   64, 0, 1, 64},
    '{ 64,   65, 1, 2,  1},
    '{ 16,   37, 2, 3,  5},
    '{100,    3, 0, 1,  3},
    '{  8,    8, 1, 1,  8},
    '{  7,   30, 0, 5,  2}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    descLenSel = '0;
  logic [AW-1:0] listBase = '0;
  logic          inValid = 1'b0;
  logic [7:0]    inData = '0;
  logic          inLast = 1'b0;
  logic          inReady;
  logic          bufWrEn;
  logic [31:0]   bufWrAddr, bufWrData;
  logic [3:0]    bufWrMask;
  logic          dmWrEn = 1'b0;
  logic [AW-1:0] dmAddr = '0;
  logic [31:0]   dmWrData = '0;
  logic [31:0]   dmRdData;

  int checks = 0;
  int fails = 0;
  int capCount = 0;
  logic [7:0] capMem [CAP];
  logic       capSet [CAP];
  logic       firstReadyLow;
  logic       sendTimeout;

  always #4 clk = ~clk;

  rx_scatter #(.DESC_WORDS(64)) uut (
    .clk(clk), .rstN(rstN), .descLenSel(descLenSel), .listBase(listBase),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .bufWrMask(bufWrMask), .dmWrEn(dmWrEn), .dmAddr(dmAddr),
    .dmWrData(dmWrData), .dmRdData(dmRdData)
  );

  // Capture buffer writes into a byte image.
  always @(negedge clk) begin
    if (rstN && bufWrEn) begin
      for (int l = 0; l < 4; l++) begin
        if (bufWrMask[l]) begin
          capMem[(bufWrAddr + l) % CAP] = bufWrData[8*l +: 8];
          capSet[(bufWrAddr + l) % CAP] = 1'b1;
          capCount++;
        end
      end
    end
  end

  function automatic logic [7:0] fb(input int i, input int s);
    return 8'((i * 13 + s * 29 + 5) & 255);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0; dmWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic clearCap();
    for (int i = 0; i < CAP; i++) begin
      capMem[i] = 8'h00;
      capSet[i] = 1'b0;
    end
    capCount = 0;
  endtask

  task automatic writeWord(input int a, input logic [31:0] d);
    @(negedge clk);
    dmWrEn = 1'b1; dmAddr = AW'(a); dmWrData = d;
    @(negedge clk);
    dmWrEn = 1'b0;
  endtask

  task automatic readWord(input int a, output logic [31:0] v);
    @(negedge clk);
    dmAddr = AW'(a);
    #1 v = dmRdData;
  endtask

  task automatic writeDesc(input int idx, input logic [31:0] w0,
                           input logic [31:0] w1, input logic [31:0] w2);
    writeWord(idx, w0);
    writeWord(idx + 1, w1);
    writeWord(idx + 2, w2);
  endtask

  task automatic sendFrame(input int len, input int seed);
    logic rdy;
    int   wait_n;
    sendTimeout = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = fb(i, seed); inLast = (i == len - 1);
      wait_n = 0;
      forever begin
        #1 rdy = inReady;
        if (i == 0 && wait_n == 0) firstReadyLow = !rdy;
        @(posedge clk);
        if (rdy) break;
        wait_n++;
        if (wait_n > 1000) begin
          sendTimeout = 1'b1;
          break;
        end
        @(negedge clk);
      end
      if (sendTimeout) break;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    vecT  cv;
    int   stride, cntK, bad;
    clearCap();

    // R1: reset state
    listBase = '0; descLenSel = 2'd0;
    doReset();
    #1;
    check(inReady == 1'b0, "R1 inReady after reset", 32'(inReady), 32'd0);
    check(bufWrEn == 1'b0, "R1 bufWrEn after reset", 32'(bufWrEn), 32'd0);
    readWord(5, v);
    check(v == 32'd0, "R1 descriptor word after reset", v, 32'd0);

    // Table of frames: R3, R4, R5, R6, R11
    for (int r = 0; r < 7; r++) begin
      cv = VEC[r];
      stride = 4 << cv.sel;
      descLenSel = 2'(cv.sel); listBase = '0;
      doReset();
      for (int k = 0; k <= cv.nBuf; k++)
        writeDesc(k * stride, 32'h8000_0100 + 32'(k), {16'(cv.capy), 16'h0},
                  32'(k * 2048));
      clearCap();
      sendFrame(cv.len, r);
      check(!sendTimeout, "R10 frame accepted", 32'(sendTimeout), 32'd0);
      check(firstReadyLow, "R10 ready low at frame start", 32'(firstReadyLow), 32'd1);
      for (int k = 0; k < cv.nBuf; k++) begin
        e = 32'h100 + 32'(k);
        if (cv.nBuf == 1)        e[29:28] = 2'b11;
        else if (k == 0)         e[29:28] = 2'b10;
        else if (k == cv.nBuf-1) e[29:28] = 2'b01;
        else                     e[29:28] = 2'b00;
        readWord(k * stride, v);
        check(v == e, "R4 R6 R11 word0 write-back", v, e);
        cntK = (k == cv.nBuf - 1) ? cv.lastCnt : cv.capy;
        readWord(k * stride + 1, v);
        check(v == {16'(cv.capy), 16'(cntK)}, "R3 R4 count write-back", v,
              {16'(cv.capy), 16'(cntK)});
        readWord(k * stride + 2, v);
        check(v == 32'(k * 2048), "R11 address word kept", v, 32'(k * 2048));
        bad = 0;
        for (int j = 0; j < cntK; j++)
          if (!capSet[k*2048+j] || capMem[k*2048+j] != fb(k * cv.capy + j, r)) bad++;
        check(bad == 0, "R5 buffer contents", 32'(bad), 32'd0);
      end
      readWord(cv.nBuf * stride, v);
      check(v == 32'h8000_0100 + 32'(cv.nBuf), "R3 R6 next descriptor untouched", v,
            32'h8000_0100 + 32'(cv.nBuf));
      check(capCount == cv.len, "R5 byte count on bus", 32'(capCount), 32'(cv.len));
    end

    // R7 wrap to list base, R2 low address bits ignored
    descLenSel = 2'd0; listBase = AW'(8);
    doReset();
    writeDesc(8,  32'h8000_0011, {16'd4, 16'd0}, 32'h0000_0002);
    writeDesc(12, 32'hC000_0012, {16'd4, 16'd0}, 32'h0000_0800);
    writeDesc(16, 32'h8000_0013, {16'd4, 16'd0}, 32'h0000_1000);
    clearCap();
    sendFrame(8, 9);
    readWord(12, v);
    check(v == 32'h5000_0012, "R7 wrap bit kept, last buffer", v, 32'h5000_0012);
    check(capSet[0] && capMem[0] == fb(0, 9), "R2 low address bits ignored",
          32'(capMem[0]), 32'(fb(0, 9)));
    writeWord(8, 32'h8000_0011);
    writeWord(9, {16'd4, 16'd0});
    clearCap();
    sendFrame(3, 10);
    readWord(9, v);
    check(v == {16'd4, 16'd3}, "R7 frame after wrap uses list base", v, {16'd4, 16'd3});
    readWord(16, v);
    check(v == 32'h8000_0013, "R7 descriptor past wrap untouched", v, 32'h8000_0013);
    check(capCount == 3 && capMem[2] == fb(2, 10), "R7 bytes at base buffer",
          32'(capCount), 32'd3);

    // R8 invalid next descriptor mid-frame
    descLenSel = 2'd0; listBase = '0;
    doReset();
    writeDesc(0, 32'h8000_0021, {16'd4, 16'd0}, 32'h0000_0000);
    writeDesc(4, 32'h0000_0022, {16'd8, 16'd0}, 32'h0000_0800);
    clearCap();
    sendFrame(10, 11);
    check(!sendTimeout, "R8 remaining bytes accepted", 32'(sendTimeout), 32'd0);
    readWord(0, v);
    check(v == 32'h2800_0021, "R8 overflow flag in previous descriptor", v, 32'h2800_0021);
    check(capCount == 4, "R8 dropped bytes not written", 32'(capCount), 32'd4);
    readWord(4, v);
    check(v == 32'h0000_0022, "R8 invalid descriptor unchanged", v, 32'h0000_0022);
    writeWord(4, 32'h8000_0022);
    clearCap();
    sendFrame(2, 12);
    readWord(5, v);
    check(v == {16'd8, 16'd2}, "R8 next frame uses same descriptor", v, {16'd8, 16'd2});
    check(capSet[2048] && capMem[2049] == fb(1, 12), "R8 next frame data",
          32'(capMem[2049]), 32'(fb(1, 12)));

    // R9 invalid descriptor at frame start
    doReset();
    writeDesc(0, 32'h0000_0031, {16'd4, 16'd0}, 32'h0000_0000);
    clearCap();
    sendFrame(5, 13);
    check(!sendTimeout && capCount == 0, "R9 frame discarded", 32'(capCount), 32'd0);
    readWord(1, v);
    check(v == {16'd4, 16'd0}, "R9 no write-back", v, {16'd4, 16'd0});
    writeWord(0, 32'h8000_0031);
    sendFrame(2, 14);
    readWord(1, v);
    check(v == {16'd4, 16'd2}, "R9 pointer held", v, {16'd4, 16'd2});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule